// File: doc/BRIEF.md
# Frame Clock Ratio Monitor with Status Word

This block watches an audio frame clock from inside the master clock domain. It measures how many master clock cycles fit between two consecutive rising edges of the frame clock. It then compares that figure with the nominal ratio, which configuration sets to 128 or 256. If the measured period strays more than ten cycles from the nominal value, a frame error flag is raised. The flag is held until the next rising edge gives a new measurement.

The block also forms a 16-bit read-only health word. The word holds a fixed identification code in its upper byte. Its low bits carry four flags: volume ramp busy, all-good (no internal error and every output valid), the frame error, and a loss-of-lock indication from the clock generator. A host reads the word through an address and read-strobe port. Read data returns one cycle after the strobe.

Top module: `frame_ratio_monitor`

## Requirements
- R1: After a synchronous reset, `frm_err_o` is 0, `rd_valid_o` is 0 and `rd_data_o` is 0.
- R2: The measured period is the number of `clk` cycles between two consecutive rising edges of `frm_clk_i`. The nominal period is 128 when `ratio_sel_i` is 0 and 256 when it is 1.
- R3: At each rising edge of the frame clock, `frm_err_o` becomes 1 if the measured period differs from the nominal period by more than 10. Otherwise it becomes 0. Between edges it keeps its value.
- R4: The first rising edge after reset only starts a measurement. `frm_err_o` stays 0 until the second rising edge has been evaluated.
- R5: A period longer than the counter range saturates the count at its maximum value (1023 by default) and is reported as an error. The count does not wrap.
- R6: A strobe on `rd_en_i` gives `rd_valid_o` = 1 on the next cycle. When `rd_addr_i` is 0, `rd_data_o` holds the status word sampled at the strobe:
  - bits 15:8: device identification (default 8'hA5)
  - bits 7:4: zero
  - bit 3: `clk_loss_i`
  - bit 2: frame error
  - bit 1: all-good
  - bit 0: `vol_busy_i`
- R7: The all-good bit (bit 1) is 1 exactly when every bit of `valid_i` is 1 and `int_err_i` is 0.
- R8: A read of any non-zero address returns 0 with `rd_valid_o` = 1. A cycle without a strobe gives `rd_valid_o` = 0 and `rd_data_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_clk_i | input | 1 | Frame clock, asynchronous to `clk` |
| ratio_sel_i | input | 1 | Nominal ratio: 0 selects 128, 1 selects 256 |
| vol_busy_i | input | 1 | Volume change in progress |
| valid_i | input | NVALID (6) | Per-output valid indications |
| int_err_i | input | 1 | Internal error present |
| clk_loss_i | input | 1 | Clock generator out of lock |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | ADDR_W (2) | Read address |
| rd_valid_o | output | 1 | Read data valid, one cycle after the strobe |
| rd_data_o | output | 16 | Read data |
| frm_err_o | output | 1 | Frame ratio error flag |

## Verification
The assertions assume two things about the frame clock. First, its rising edges are at least a few master cycles apart. This lets the one-cycle edge pulse fall before the next edge arrives. Second, the counter restart and the error update depend only on that pulse. The stimulus drives the frame clock and all other inputs on the falling edge of `clk`, so the synchronizer sees clean transitions and the measured period equals the programmed period exactly. Every period the bench applies is at least five cycles long. The bench sweeps the period across each side of both tolerance windows, and also drives one overlong frame to show saturation.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

    localparam int STATUS_W = 16;
    localparam int DEVID_W  = 8;

    typedef enum logic {
        RATIO_128 = 1'b0,
        RATIO_256 = 1'b1
    } ratio_e;

    typedef struct packed {
        logic [DEVID_W-1:0] dev_id;
        logic [3:0]         rsvd;
        logic               clk_loss;
        logic               frm_err;
        logic               all_ok;
        logic               vol_busy;
    } status_t;

    function automatic int unsigned nominal_period(ratio_e r);
        return (r == RATIO_256) ? 32'd256 : 32'd128;
    endfunction

    function automatic logic beyond_tol(int unsigned meas, int unsigned nom,
                                        int unsigned tol);
        int unsigned diff;
        diff = (meas > nom) ? (meas - nom) : (nom - meas);
        return diff > tol;
    endfunction

endpackage

// File: rtl/fcm_edge_sync.sv
module fcm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], async_i};
    end

    assign rise_o = sh[STAGES-1] & ~sh[STAGES];

    // R2
    rise_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o);

endmodule

// File: rtl/fcm_period_meter.sv
module fcm_period_meter
    import fcm_pkg::*;
#(
    parameter int          CNT_W = 10,
    parameter int unsigned TOL   = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   rise_i,
    input  ratio_e ratio_i,
    output logic   err_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b0;
            err_q <= 1'b0;
        end else if (rise_i) begin
            cnt   <= CNT_W'(1);
            armed <= 1'b1;
            if (armed)
                err_q <= beyond_tol(32'(cnt), nominal_period(ratio_i), TOL);
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign err_o = err_q;

    // R3
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rise_i |=> $stable(err_q));

    // R4
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !err_q);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        rise_i |=> (cnt == CNT_W'(1)));

    // R5
    saturate_chk: assert property (@(posedge clk) disable iff (rst)
        (!rise_i && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/fcm_status_regs.sv
module fcm_status_regs
    import fcm_pkg::*;
#(
    parameter logic [DEVID_W-1:0] DEV_ID = 8'hA5,
    parameter int                 NVALID = 6,
    parameter int                 ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    input  logic                vol_busy_i,
    input  logic [NVALID-1:0]   valid_i,
    input  logic                int_err_i,
    input  logic                frm_err_i,
    input  logic                clk_loss_i,
    output logic                rd_valid_o,
    output logic [STATUS_W-1:0] rd_data_o
);
    localparam logic [ADDR_W-1:0] STATUS_ADDR = '0;

    status_t word;

    always_comb begin
        word          = '0;
        word.dev_id   = DEV_ID;
        word.clk_loss = clk_loss_i;
        word.frm_err  = frm_err_i;
        word.all_ok   = (&valid_i) & ~int_err_i;
        word.vol_busy = vol_busy_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= rd_en_i;
            rd_data_o  <= (rd_en_i && rd_addr_i == STATUS_ADDR) ? word : '0;
        end
    end

    // R6
    rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_i |=> rd_valid_o);

    // R6
    dev_id_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && rd_addr_i == STATUS_ADDR) |=> (rd_data_o[15:8] == DEV_ID));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> (!rd_valid_o && rd_data_o == '0));

endmodule

// File: rtl/frame_ratio_monitor.sv
module frame_ratio_monitor
    import fcm_pkg::*;
#(
    parameter int                 CNT_W       = 10,
    parameter int unsigned        TOL         = 10,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 NVALID      = 6,
    parameter int                 ADDR_W      = 2,
    parameter logic [DEVID_W-1:0] DEV_ID      = 8'hA5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                frm_clk_i,
    input  logic                ratio_sel_i,
    input  logic                vol_busy_i,
    input  logic [NVALID-1:0]   valid_i,
    input  logic                int_err_i,
    input  logic                clk_loss_i,
    input  logic                rd_en_i,
    input  logic [ADDR_W-1:0]   rd_addr_i,
    output logic                rd_valid_o,
    output logic [STATUS_W-1:0] rd_data_o,
    output logic                frm_err_o
);
    logic   rise;
    logic   err;
    ratio_e ratio;

    assign ratio = ratio_e'(ratio_sel_i);

    fcm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (frm_clk_i),
        .rise_o  (rise)
    );

    fcm_period_meter #(.CNT_W(CNT_W), .TOL(TOL)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (rise),
        .ratio_i (ratio),
        .err_o   (err)
    );

    fcm_status_regs #(.DEV_ID(DEV_ID), .NVALID(NVALID), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .vol_busy_i (vol_busy_i),
        .valid_i    (valid_i),
        .int_err_i  (int_err_i),
        .frm_err_i  (err),
        .clk_loss_i (clk_loss_i),
        .rd_valid_o (rd_valid_o),
        .rd_data_o  (rd_data_o)
    );

    assign frm_err_o = err;

endmodule

// File: tb/tb_frame_ratio_monitor.sv
`timescale 1ns/1ps
module tb_frame_ratio_monitor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frm_clk_i = 1'b0;
    logic        ratio_sel_i = 1'b0;
    logic        vol_busy_i = 1'b0;
    logic [5:0]  valid_i = '0;
    logic        int_err_i = 1'b0;
    logic        clk_loss_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  rd_addr_i = '0;
    logic        rd_valid_o;
    logic [15:0] rd_data_o;
    logic        frm_err_o;

    int vecs = 0;
    int fails = 0;
    logic err_exp = 1'b0;

    always #5 clk = ~clk;

    frame_ratio_monitor dut (
        .clk(clk), .rst(rst), .frm_clk_i(frm_clk_i), .ratio_sel_i(ratio_sel_i),
        .vol_busy_i(vol_busy_i), .valid_i(valid_i), .int_err_i(int_err_i),
        .clk_loss_i(clk_loss_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .frm_err_o(frm_err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frames(input int p, input int n);
        for (int f = 0; f < n; f++) begin
            @(negedge clk) frm_clk_i = 1'b1;
            for (int i = 0; i < p / 2; i++) @(negedge clk);
            frm_clk_i = 1'b0;
            for (int i = 0; i < p - p / 2 - 1; i++) @(negedge clk);
        end
    endtask

    task automatic do_read(input logic [1:0] a);
        @(negedge clk);
        rd_en_i = 1'b1;
        rd_addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 err", 32'(frm_err_o), 0);
        chk("R1 rd_valid", 32'(rd_valid_o), 0);
        chk("R1 rd_data", 32'(rd_data_o), 0);

        // R4: first edge only arms, second edge evaluates a 5-cycle period
        frames(5, 1);
        chk("R4 first edge ignored", 32'(frm_err_o), 0);
        frames(5, 1);
        chk("R3 short period after arming", 32'(frm_err_o), 1);

        // R2/R3 sweep across both tolerance windows
        for (int r = 0; r < 2; r++) begin
            int nom;
            ratio_sel_i = r[0];
            nom = (r == 0) ? 128 : 256;
            for (int p = nom - 14; p <= nom + 14; p++) begin
                int d;
                frames(p, 3);
                d = (p > nom) ? p - nom : nom - p;
                err_exp = (d > 10);
                chk(r == 0 ? "R2 R3 ratio128" : "R2 R3 ratio256", 32'(frm_err_o), 32'(err_exp));
            end
        end

        // R5: 1280 would wrap to 256 in a 10-bit counter; saturation flags it
        ratio_sel_i = 1'b1;
        frames(1280, 2);
        err_exp = 1'b1;
        chk("R5 saturated period", 32'(frm_err_o), 1);
        do_read(2'd0);
        chk("R5 status bit2", 32'(rd_data_o[2]), 1);
        frames(256, 2);
        err_exp = 1'b0;
        chk("R3 recovery", 32'(frm_err_o), 0);

        // R6/R7: status word across all flag combinations
        for (int v = 0; v < 64; v++) begin
            for (int m = 0; m < 8; m++) begin
                logic [15:0] exp_w;
                valid_i = v[5:0];
                vol_busy_i = m[0];
                int_err_i = m[1];
                clk_loss_i = m[2];
                exp_w = {8'hA5, 4'b0000, m[2], err_exp, ((v == 63) && !m[1]), m[0]};
                do_read(2'd0);
                chk("R6 R7 status word", 32'(rd_data_o), 32'(exp_w));
                chk("R6 rd_valid", 32'(rd_valid_o), 1);
            end
        end

        // R8: other addresses and idle cycles
        for (int a = 1; a < 4; a++) begin
            do_read(a[1:0]);
            chk("R8 other addr data", 32'(rd_data_o), 0);
            chk("R8 other addr valid", 32'(rd_valid_o), 1);
        end
        @(negedge clk);
        chk("R8 idle valid", 32'(rd_valid_o), 0);
        chk("R8 idle data", 32'(rd_data_o), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule